// File: doc/BRIEF.md
# Data Breakpoint Match Controller

This block sits beside the load/store stage of a processor pipeline and watches every data access against a small bank of breakpoint channels. Each channel holds a compare address and a don't-care mask. It also has separate arm bits for loads and for stores, plus an optional data-value compare restricted to selected byte lanes. For every access the block tells the pipeline three things: whether the memory read may go out, whether the register writeback must be dropped, and whether a store must be held back. It raises a one-cycle debug exception request and sets sticky per-channel status bits that only software can clear.

Channels without value compare are resolved when the address is decoded. A value-compare channel on a load needs the loaded data before it can be resolved. The read is therefore issued and the decision is taken when the data returns; on a hit the data is thrown away. When channels of both kinds hit the same load, the read is never issued. Only the address-only channels report, because the value-compare ones cannot be decided. On stores the write data is at hand, so every channel that fully matches reports. The pipeline keeps at most one load outstanding: its data returns before the next load is presented.

Top module: `dbrk_match_ctrl`

## Requirements
- R1: A channel hits an access when `((acc_addr_i ^ addr) & ~mask) == 0` and the channel is armed for that access type (ctrl bit 0 arms loads, bit 1 arms stores). Ctrl bit 2 turns on value compare. After reset every channel is disarmed.
- R2: A load that hits at least one address-only channel drives `mem_rd_en_o` low and `wb_suppress_o` high in the access cycle. At the next edge it sets the status bits of exactly those address-only channels. Value-compare channels hit by the same load keep their status bits.
- R3: A store drives `st_block_o` high in its cycle when at least one channel is a full hit. A full hit is an address-only channel that hits, or a value-compare channel that hits with matching store data. At the next edge the status bits of all fully hitting channels are set.
- R4: A load that hits only value-compare channels keeps `mem_rd_en_o` high and `wb_suppress_o` low in its cycle. In the cycle `rdata_valid_i` is high, `wb_suppress_o` goes high if any of those channels matches `rdata_i`. At the next edge their status bits are set.
- R5: The value compare checks byte lane b (data bits 8b+7..8b) only when lane-enable bit b is set. The lane enables are ctrl bits 3+b. With no lanes enabled the value always matches.
- R6: Status bits are sticky. A bit stays set until `sts_clr_i` for that channel is high at an edge.
- R7: When a clear and a hit set the same status bit at the same edge, the bit ends up set.
- R8: An access that hits no channel leaves status unchanged and raises no exception. A load keeps `mem_rd_en_o` high; nothing is suppressed or blocked.
- R9: `dbg_exc_o` is high for exactly the cycle after each edge at which a hit sets status bits, and low otherwise.
- R10: Configuration writes use `cfg_sel_i`: 0 writes the address, 1 the mask, 2 the compare value, 3 the control field of channel `cfg_ch_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ch_i | input | 2 | Channel selected for the write |
| cfg_sel_i | input | 2 | Field selected for the write |
| cfg_wdata_i | input | 32 | Write data |
| sts_clr_i | input | 4 | Per-channel status clear |
| acc_valid_i | input | 1 | Access presented this cycle |
| acc_store_i | input | 1 | 1 = store, 0 = load |
| acc_addr_i | input | 32 | Access address |
| acc_wdata_i | input | 32 | Store data |
| rdata_valid_i | input | 1 | Load data returning this cycle |
| rdata_i | input | 32 | Returned load data |
| mem_rd_en_o | output | 1 | Load read may be issued |
| wb_suppress_o | output | 1 | Drop register writeback |
| st_block_o | output | 1 | Hold back the store commit |
| dbg_exc_o | output | 1 | Debug exception request pulse |
| sts_o | output | 4 | Sticky break status per channel |

## Verification
The bench uses the defaults: four channels and 32-bit address and data, so there are four byte lanes. With four channels, one access can hit address-only and value-compare channels together. That reaches the mixed-load precedence and the mixed-store case. The random configurations draw addresses from a small pool with low-order masks, and value lanes are enabled at random. This makes hits, partial lane matches and clears that coincide with sets frequent.

// File: rtl/dbrk_pkg.sv
package dbrk_pkg;
  typedef enum logic [1:0] {
    CFG_ADDR = 2'd0,
    CFG_MASK = 2'd1,
    CFG_VAL  = 2'd2,
    CFG_CTRL = 2'd3
  } cfg_sel_e;

  localparam int unsigned CTRL_LD   = 0;
  localparam int unsigned CTRL_ST   = 1;
  localparam int unsigned CTRL_VC   = 2;
  localparam int unsigned CTRL_LANE = 3;
endpackage

// File: rtl/dbrk_chan.sv
module dbrk_chan
  import dbrk_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [CW-1:0] wdata_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [DW-1:0] st_data_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          ld_hit_o,
  output logic          st_hit_o,
  output logic          vc_o,
  output logic          st_vmatch_o,
  output logic          rd_vmatch_o
);
  localparam int unsigned NB = DW / 8;

  logic [AW-1:0] addr_q, mask_q;
  logic [DW-1:0] val_q;
  logic          ld_en_q, st_en_q, vc_q;
  logic [NB-1:0] lane_q;
  logic [NB-1:0] st_ok, rd_ok;
  logic          addr_eq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      mask_q  <= '0;
      val_q   <= '0;
      ld_en_q <= 1'b0;
      st_en_q <= 1'b0;
      vc_q    <= 1'b0;
      lane_q  <= '0;
    end else if (we_i) begin
      case (cfg_sel_e'(sel_i))
        CFG_ADDR: addr_q <= wdata_i[AW-1:0];
        CFG_MASK: mask_q <= wdata_i[AW-1:0];
        CFG_VAL:  val_q  <= wdata_i[DW-1:0];
        default: begin
          ld_en_q <= wdata_i[CTRL_LD];
          st_en_q <= wdata_i[CTRL_ST];
          vc_q    <= wdata_i[CTRL_VC];
          lane_q  <= wdata_i[CTRL_LANE +: NB];
        end
      endcase
    end
  end

  assign addr_eq = ((acc_addr_i ^ addr_q) & ~mask_q) == '0;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign st_ok[b] = ~lane_q[b] | (st_data_i[8*b +: 8] == val_q[8*b +: 8]);
    assign rd_ok[b] = ~lane_q[b] | (rd_data_i[8*b +: 8] == val_q[8*b +: 8]);
  end

  assign ld_hit_o    = addr_eq & ld_en_q;
  assign st_hit_o    = addr_eq & st_en_q;
  assign vc_o        = vc_q;
  assign st_vmatch_o = &st_ok;
  assign rd_vmatch_o = &rd_ok;
endmodule

// File: rtl/dbrk_resolve.sv
module dbrk_resolve #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           acc_valid_i,
  input  logic           acc_store_i,
  input  logic           rdata_valid_i,
  input  logic [NCH-1:0] ld_hit_i,
  input  logic [NCH-1:0] st_hit_i,
  input  logic [NCH-1:0] vc_i,
  input  logic [NCH-1:0] st_vmatch_i,
  input  logic [NCH-1:0] rd_vmatch_i,
  output logic [NCH-1:0] set_o,
  output logic           mem_rd_en_o,
  output logic           wb_suppress_o,
  output logic           st_block_o,
  output logic           dbg_exc_o
);
  logic           ld_acc, st_acc, ld_ao_any;
  logic [NCH-1:0] ao_ld, vc_ld, st_full, st_set, ld_set, rd_set;
  logic [NCH-1:0] pend_q;
  logic           exc_q;

  assign ld_acc    = acc_valid_i & ~acc_store_i;
  assign st_acc    = acc_valid_i & acc_store_i;
  assign ao_ld     = ld_hit_i & ~vc_i;
  assign vc_ld     = ld_hit_i & vc_i;
  assign ld_ao_any = ld_acc & (|ao_ld);
  assign st_full   = (st_hit_i & ~vc_i) | (st_hit_i & vc_i & st_vmatch_i);

  assign st_set = st_acc ? st_full : '0;
  // address-only hits take precedence: value channels stay undecided
  assign ld_set = ld_ao_any ? ao_ld : '0;
  assign rd_set = rdata_valid_i ? (pend_q & rd_vmatch_i) : '0;
  assign set_o  = st_set | ld_set | rd_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      exc_q  <= 1'b0;
    end else begin
      if (ld_acc)             pend_q <= ld_ao_any ? '0 : vc_ld;
      else if (rdata_valid_i) pend_q <= '0;
      exc_q <= |set_o;
    end
  end

  assign mem_rd_en_o   = ld_acc & ~ld_ao_any;
  assign wb_suppress_o = ld_ao_any | (|rd_set);
  assign st_block_o    = |st_set;
  assign dbg_exc_o     = exc_q;

  a_r2_no_read_on_ao: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_store_i && wb_suppress_o && !rdata_valid_i) |-> !mem_rd_en_o);
  a_r3_block_raises_exc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_block_o |=> dbg_exc_o);
  a_r4_no_suppress_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_valid_i && rdata_valid_i && pend_q == '0) |-> !wb_suppress_o);
  a_r8_quiet_no_exc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_valid_i && !rdata_valid_i) |=> !dbg_exc_o);
  a_r3_block_only_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_block_o |-> (acc_valid_i && acc_store_i));
endmodule

// File: rtl/dbrk_status.sv
module dbrk_status #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] sts_o
);
  logic [NCH-1:0] sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~clr_i) | set_i;
  end

  assign sts_o = sts_q;

  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_q & $past(sts_q & ~clr_i)) == $past(sts_q & ~clr_i)));
  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/dbrk_match_ctrl.sv
module dbrk_match_ctrl #(
  parameter int unsigned NCH  = 4,
  parameter int unsigned AW   = 32,
  parameter int unsigned DW   = 32,
  localparam int unsigned CW  = (AW > DW) ? AW : DW,
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic [CHW-1:0] cfg_ch_i,
  input  logic [1:0]     cfg_sel_i,
  input  logic [CW-1:0]  cfg_wdata_i,
  input  logic [NCH-1:0] sts_clr_i,
  input  logic           acc_valid_i,
  input  logic           acc_store_i,
  input  logic [AW-1:0]  acc_addr_i,
  input  logic [DW-1:0]  acc_wdata_i,
  input  logic           rdata_valid_i,
  input  logic [DW-1:0]  rdata_i,
  output logic           mem_rd_en_o,
  output logic           wb_suppress_o,
  output logic           st_block_o,
  output logic           dbg_exc_o,
  output logic [NCH-1:0] sts_o
);
  logic [NCH-1:0] ld_hit, st_hit, vc, st_vm, rd_vm, set;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dbrk_chan #(.AW(AW), .DW(DW), .CW(CW)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .we_i        (cfg_we_i && (cfg_ch_i == CHW'(g))),
      .sel_i       (cfg_sel_i),
      .wdata_i     (cfg_wdata_i),
      .acc_addr_i  (acc_addr_i),
      .st_data_i   (acc_wdata_i),
      .rd_data_i   (rdata_i),
      .ld_hit_o    (ld_hit[g]),
      .st_hit_o    (st_hit[g]),
      .vc_o        (vc[g]),
      .st_vmatch_o (st_vm[g]),
      .rd_vmatch_o (rd_vm[g])
    );
  end

  dbrk_resolve #(.NCH(NCH)) u_resolve (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .acc_valid_i   (acc_valid_i),
    .acc_store_i   (acc_store_i),
    .rdata_valid_i (rdata_valid_i),
    .ld_hit_i      (ld_hit),
    .st_hit_i      (st_hit),
    .vc_i          (vc),
    .st_vmatch_i   (st_vm),
    .rd_vmatch_i   (rd_vm),
    .set_o         (set),
    .mem_rd_en_o   (mem_rd_en_o),
    .wb_suppress_o (wb_suppress_o),
    .st_block_o    (st_block_o),
    .dbg_exc_o     (dbg_exc_o)
  );

  dbrk_status #(.NCH(NCH)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set),
    .clr_i  (sts_clr_i),
    .sts_o  (sts_o)
  );

  a_r9_exc_has_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_exc_o |-> (sts_o != '0));
  a_r8_no_hit_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_store_i && ld_hit == '0) |-> (mem_rd_en_o && !wb_suppress_o));
endmodule

// File: tb/dbrk_match_ctrl_tb.sv
module dbrk_match_ctrl_tb_top;
  localparam int NCH = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_ch_i = '0;
  logic [1:0]  cfg_sel_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [3:0]  sts_clr_i = '0;
  logic        acc_valid_i = 1'b0;
  logic        acc_store_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic [31:0] acc_wdata_i = '0;
  logic        rdata_valid_i = 1'b0;
  logic [31:0] rdata_i = '0;
  logic        mem_rd_en_o, wb_suppress_o, st_block_o, dbg_exc_o;
  logic [3:0]  sts_o;

  dbrk_match_ctrl dut_i (.*);

  always #5 clk_i = ~clk_i;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] m_addr[NCH], m_mask[NCH], m_val[NCH], m_ctrl[NCH];
  logic [3:0]  exp_sts;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit vmatch(int c, logic [31:0] d);
    for (int b = 0; b < 4; b++)
      if (m_ctrl[c][3+b] && d[8*b +: 8] != m_val[c][8*b +: 8]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit ahit(int c, logic [31:0] a, bit st);
    bit en = st ? m_ctrl[c][1] : m_ctrl[c][0];
    return en && (((a ^ m_addr[c]) & ~m_mask[c]) == 32'h0);
  endfunction

  task automatic cfg(int c, int sel, logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_ch_i = 2'(c); cfg_sel_i = 2'(sel); cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    case (sel)
      0: m_addr[c] = d;
      1: m_mask[c] = d;
      2: m_val[c] = d;
      default: m_ctrl[c] = d;
    endcase
  endtask

  task automatic setup(int c, logic [31:0] a, logic [31:0] mk, logic [31:0] v, logic [31:0] ct);
    cfg(c, 0, a); cfg(c, 1, mk); cfg(c, 2, v); cfg(c, 3, ct);
  endtask

  // one access; for reads a data return cycle follows
  task automatic access(bit st, logic [31:0] a, logic [31:0] wd, logic [31:0] rd, logic [3:0] clr);
    logic [3:0] ao, vc, set_now, pend, rset;
    @(negedge clk_i);
    acc_valid_i = 1'b1; acc_store_i = st; acc_addr_i = a; acc_wdata_i = wd; sts_clr_i = clr;
    #1;
    ao = '0; vc = '0;
    for (int c = 0; c < NCH; c++)
      if (ahit(c, a, st)) begin
        if (m_ctrl[c][2]) vc[c] = 1'b1; else ao[c] = 1'b1;
      end
    pend = '0;
    if (st) begin
      set_now = ao;
      for (int c = 0; c < NCH; c++) if (vc[c] && vmatch(c, wd)) set_now[c] = 1'b1;
      chk("R3 st_block", st_block_o, set_now != 0);
      chk("R8 st no read", mem_rd_en_o, 0);
      chk("R8 st no suppress", wb_suppress_o, 0);
    end else begin
      set_now = ao;
      if (ao == 0) pend = vc;
      chk(ao != 0 ? "R2 rd_en" : "R4/R8 rd_en", mem_rd_en_o, ao == 0);
      chk(ao != 0 ? "R2 suppress" : "R4 suppress at decode", wb_suppress_o, ao != 0);
      chk("R8 ld no block", st_block_o, 0);
    end
    exp_sts = (exp_sts & ~clr) | set_now;
    @(negedge clk_i);
    acc_valid_i = 1'b0; sts_clr_i = '0;
    #1;
    chk("R6/R7 sts after access", sts_o, exp_sts);
    chk("R9 exc after access", dbg_exc_o, set_now != 0);
    if (!st && ao == 0) begin
      rdata_valid_i = 1'b1; rdata_i = rd;
      #1;
      rset = '0;
      for (int c = 0; c < NCH; c++) if (pend[c] && vmatch(c, rd)) rset[c] = 1'b1;
      chk("R4 suppress on data", wb_suppress_o, rset != 0);
      exp_sts = exp_sts | rset;
      @(negedge clk_i);
      rdata_valid_i = 1'b0;
      #1;
      chk("R4/R5 sts after data", sts_o, exp_sts);
      chk("R9 exc after data", dbg_exc_o, rset != 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < NCH; c++) begin
      m_addr[c] = 0; m_mask[c] = 0; m_val[c] = 0; m_ctrl[c] = 0;
    end
    exp_sts = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R1 reset sts", sts_o, 0);
    chk("R9 reset exc", dbg_exc_o, 0);
    // R1 disarmed after reset: address 0 must not hit
    access(1'b0, 32'h0, 0, 0, 0);
    access(1'b1, 32'h0, 0, 0, 0);

    // ch0 addr-only load+store, ch1 value compare all lanes, ch2 value lane0 only
    setup(0, 32'h1000, 32'h3, 0, 32'h3);
    setup(1, 32'h1000, 32'hF, 32'hCAFE_BEEF, 32'h7 | (32'hF << 3));
    setup(2, 32'h2000, 32'h0, 32'h0000_00AA, 32'h7 | (32'h1 << 3));
    // R2 mixed load: only ch0 sets
    access(1'b0, 32'h1002, 0, 32'hCAFE_BEEF, 0);
    chk("R2 mixed load only ao", sts_o, 4'b0001);
    // R6 sticky, clear ch0
    access(1'b0, 32'h3000, 0, 0, 4'b0001);
    chk("R6 cleared", sts_o, 4'b0000);
    // R4 value-only load with match and mismatch (outside ch0 mask)
    access(1'b0, 32'h1008, 0, 32'h1111_1111, 0);
    access(1'b0, 32'h1008, 0, 32'hCAFE_BEEF, 0);
    chk("R4 value load", sts_o, 4'b0010);
    // R5 lane mask: only lane 0 compared
    access(1'b0, 32'h2000, 0, 32'h1234_56AA, 0);
    chk("R5 lane0 only", sts_o, 4'b0110);
    // R3 mixed store sets all full hits; R7 clear+set
    access(1'b1, 32'h1001, 32'hCAFE_BEEF, 0, 4'b0011);
    chk("R3 R7 mixed store", sts_o, 4'b0111);
    access(1'b1, 32'h1001, 32'h0, 0, 4'b0111);
    chk("R3 store ao only", sts_o, 4'b0001);
    // R8 miss
    access(1'b1, 32'h9000, 0, 0, 0);

    // R10/R1 random configurations and accesses
    for (int it = 0; it < 40; it++) begin
      for (int c = 0; c < NCH; c++)
        setup(c, {20'h0, 4'($urandom_range(0, 3)), 8'h00}, 32'($urandom_range(0, 3)),
              {8'h5A, 8'hA5, 8'h5A, 8'($urandom_range(0, 1))},
              32'($urandom) & 32'h7F);
      for (int k = 0; k < 12; k++)
        access(1'($urandom), {20'h0, 4'($urandom_range(0, 3)), 6'h0, 2'($urandom)},
               {8'h5A, 8'(($urandom & 1) ? 8'hA5 : 8'h00), 8'h5A, 8'($urandom_range(0, 1))},
               {8'h5A, 8'(($urandom & 1) ? 8'hA5 : 8'h00), 8'h5A, 8'($urandom_range(0, 1))},
               4'($urandom));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule